// File: doc/BRIEF.md
# Line Reference Divider and Phase Comparator

This block sits in the acquisition clock tree of a line-locked video front end. It derives an acquisition clock from a fast base clock with a divide-by-two stage, which gives an exact 50% duty cycle. It then counts acquisition cycles modulo a line length to build a clock-synchronous line reference, which is high for the first half of each line and low for the second. A select input can replace the internal half-rate clock with an external acquisition clock. The external clock is sampled by the base clock and must run at less than half the base rate. In that mode the horizontal sync is taken to be synchronous to the external clock.

The incoming horizontal sync passes through a synchroniser and a rising-edge detector, both clocked by acquisition cycles. The block timestamps each detected edge against the line counter. It reports how far that edge sits from the rising edge of the reference, as a signed count of acquisition cycles wrapped into one line, with a one-cycle valid strobe. An external loop filter uses this error to steer the oscillator. When no sync edge appears for a full line, a flag is raised and the last error value is kept.

Top module: `line_ref_phase_det`

## Requirements
- R1: With internal source selected (`sel_ext_i` = 0), `acq_clk_o` inverts on every base clock edge, giving a period of two base cycles and 50% duty.
- R2: `line_ref_o` changes only on acquisition clock rising edges. It is high for exactly LINE_LEN/2 acquisition cycles starting where the line count wraps to 0, then low for LINE_LEN/2 cycles.
- R3: Let c be the line count (acquisition cycles since the rising edge of `line_ref_o`) in the cycle in which the synchroniser first samples `hsync_i` high. Then `phase_err_o` is -c wrapped into [-LINE_LEN/2, LINE_LEN/2-1], as a two's complement value of log2(LINE_LEN)+1 bits.
- R4: `err_valid_o` is high for exactly one base clock cycle for each detected sync edge.
- R5: `err_valid_o` rises at the (SYNC_STAGES+1)-th acquisition clock rising edge after `hsync_i` goes high.
- R6: Only a low-to-high transition of the synchronised sync counts: a sync held high over several lines produces a single strobe.
- R7: `sync_missing_o` is set at the LINE_LEN-th acquisition cycle after the last detected edge (or reset) without a new edge. While no edge is detected, `phase_err_o` holds its value. The next detected edge clears the flag in the same cycle that `err_valid_o` rises.
- R8: With `sel_ext_i` = 1, `acq_clk_o` equals `ext_acq_clk_i` delayed by one base cycle, and all line counting and sync sampling advance on its rising edges.
- R9: During reset `acq_clk_o` = 0, `line_ref_o` = 1 (line count 0), `phase_err_o` = 0, `err_valid_o` = 0 and `sync_missing_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base_i | input | 1 | Base clock (twice the acquisition rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ext_i | input | 1 | 1 selects the external acquisition clock |
| ext_acq_clk_i | input | 1 | External acquisition clock, sampled by the base clock |
| hsync_i | input | 1 | Horizontal sync from the video source |
| acq_clk_o | output | 1 | Acquisition clock (registered) |
| line_ref_o | output | 1 | Clock-synchronous line reference, 50% duty |
| phase_err_o | output | ERR_W | Signed sync-to-reference delay in acquisition cycles |
| err_valid_o | output | 1 | One-cycle strobe when `phase_err_o` is updated |
| sync_missing_o | output | 1 | No sync edge seen for a full line |

## Verification
The bench builds the block with LINE_LEN = 16 and SYNC_STAGES = 2. With a line that short, every sync offset within a line can be swept in both clock modes, and each error value, including the -8 and +7 extremes of the wrap, is checked against arithmetic done in the bench. The short line also brings the missing-sync timeout within reach. The bench checks it one cycle before and at the exact cycle it fires. It also checks that sync edges spaced exactly one line apart never raise the flag.

// File: rtl/lrpd_pkg.sv
package lrpd_pkg;

    // Source of the acquisition clock
    typedef enum logic {
        ACQ_INTERNAL = 1'b0,
        ACQ_EXTERNAL = 1'b1
    } acq_src_e;

endpackage

// File: rtl/lrpd_acq_gen.sv
// Acquisition clock generation: either the base clock halved, or an
// external clock resampled in the base domain. Emits a one-cycle tick on
// every rising edge of the produced acquisition clock.
module lrpd_acq_gen
    import lrpd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_ext_i,
    input  logic ext_acq_clk_i,
    output logic acq_clk_o,
    output logic tick_o
);

    typedef struct packed {
        logic acq;
    } acq_state_t;

    acq_state_t st_d, st_q;
    acq_src_e   src;

    always_comb begin
        src  = sel_ext_i ? ACQ_EXTERNAL : ACQ_INTERNAL;
        st_d = st_q;
        case (src)
            ACQ_INTERNAL: st_d.acq = ~st_q.acq;
            ACQ_EXTERNAL: st_d.acq = ext_acq_clk_i;
            default:      st_d.acq = 1'b0;
        endcase
        // tick marks the base edge where the acquisition clock rises
        tick_o = st_d.acq & ~st_q.acq;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acq_clk_o = st_q.acq;

endmodule

// File: rtl/lrpd_line_div.sv
// Line counter: counts acquisition ticks modulo LINE_LEN (a power of two).
// The reference is high during the first half of each line.
module lrpd_line_div #(
    parameter int LINE_LEN = 1024,
    localparam int LW      = $clog2(LINE_LEN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    output logic [LW-1:0] count_o,
    output logic          line_ref_o
);

    typedef struct packed {
        logic [LW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            // natural wrap: LINE_LEN is a power of two
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.cnt;
    assign line_ref_o = ~st_q.cnt[LW-1];

endmodule

// File: rtl/lrpd_sync_edge.sv
// Sync input synchroniser and rising-edge detector, advanced only on
// acquisition ticks. rise_o is asserted in the base cycle of the tick at
// which the synchronised level is first seen high.
module lrpd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic hsync_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_state_t;

    sync_state_t         st_d, st_q;
    logic [STAGES:0]     shifted;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.pipe, hsync_i};
        if (tick_i) begin
            st_d.pipe = shifted[STAGES-1:0];
            st_d.prev = st_q.pipe[STAGES-1];
        end
        rise_o = tick_i & st_q.pipe[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lrpd_phase_meas.sv
// Converts the line count at a detected sync edge into a signed phase
// error, removes the synchroniser latency, and supervises missing syncs.
module lrpd_phase_meas #(
    parameter int LINE_LEN    = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int LW         = $clog2(LINE_LEN),
    localparam int ERR_W      = LW + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic [LW-1:0]    count_i,
    output logic [ERR_W-1:0] phase_err_o,
    output logic             err_valid_o,
    output logic             sync_missing_o
);

    localparam logic [LW-1:0] LATENCY   = LW'(SYNC_STAGES);
    localparam logic [LW-1:0] MISS_LAST = LW'(LINE_LEN - 1);

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             valid;
        logic             missing;
        logic [LW-1:0]    idle;
    } meas_state_t;

    meas_state_t   st_d, st_q;
    logic [LW-1:0] err_raw;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        // count at detection is (first-sample count + latency); negate
        // the first-sample count modulo the line length
        err_raw    = LATENCY - count_i;
        if (tick_i) begin
            if (rise_i) begin
                st_d.err     = {err_raw[LW-1], err_raw};
                st_d.valid   = 1'b1;
                st_d.missing = 1'b0;
                st_d.idle    = '0;
            end else if (st_q.idle == MISS_LAST) begin
                st_d.missing = 1'b1;
            end else begin
                st_d.idle = st_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_err_o    = st_q.err;
    assign err_valid_o    = st_q.valid;
    assign sync_missing_o = st_q.missing;

endmodule

// File: rtl/line_ref_phase_det.sv
// Top: acquisition clock source, line reference divider, sync edge
// detection and digital phase comparison.
module line_ref_phase_det #(
    parameter int LINE_LEN    = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int LW         = $clog2(LINE_LEN),
    localparam int ERR_W      = LW + 1
) (
    input  logic             clk_base_i,
    input  logic             rst_ni,
    input  logic             sel_ext_i,
    input  logic             ext_acq_clk_i,
    input  logic             hsync_i,
    output logic             acq_clk_o,
    output logic             line_ref_o,
    output logic [ERR_W-1:0] phase_err_o,
    output logic             err_valid_o,
    output logic             sync_missing_o
);

    logic          tick;
    logic          rise;
    logic [LW-1:0] line_count;

    lrpd_acq_gen u_acq_gen (
        .clk_i         (clk_base_i),
        .rst_ni        (rst_ni),
        .sel_ext_i     (sel_ext_i),
        .ext_acq_clk_i (ext_acq_clk_i),
        .acq_clk_o     (acq_clk_o),
        .tick_o        (tick)
    );

    lrpd_line_div #(
        .LINE_LEN (LINE_LEN)
    ) u_line_div (
        .clk_i      (clk_base_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .count_o    (line_count),
        .line_ref_o (line_ref_o)
    );

    lrpd_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync_edge (
        .clk_i   (clk_base_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .hsync_i (hsync_i),
        .rise_o  (rise)
    );

    lrpd_phase_meas #(
        .LINE_LEN    (LINE_LEN),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_phase_meas (
        .clk_i          (clk_base_i),
        .rst_ni         (rst_ni),
        .tick_i         (tick),
        .rise_i         (rise),
        .count_i        (line_count),
        .phase_err_o    (phase_err_o),
        .err_valid_o    (err_valid_o),
        .sync_missing_o (sync_missing_o)
    );

endmodule

// File: rtl/lrpd_checker.sv
// Property checker attached to the top module.
module lrpd_checker #(
    parameter int ERR_W = 11
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sel_ext_i,
    input logic             acq_clk_o,
    input logic             line_ref_o,
    input logic [ERR_W-1:0] phase_err_o,
    input logic             err_valid_o,
    input logic             sync_missing_o
);

    // R1: internal source toggles the acquisition clock every base cycle
    a_r1_internal_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(sel_ext_i)) |-> (acq_clk_o != $past(acq_clk_o)));

    // R2: the line reference only moves with an acquisition rising edge
    a_r2_ref_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$stable(line_ref_o)) |-> $rose(acq_clk_o));

    // R4: the valid strobe lasts a single base cycle
    a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_valid_o |=> !err_valid_o);

    // R7: the error only changes together with a strobe
    a_r7_err_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$stable(phase_err_o)) |-> err_valid_o);

    // R7: a fresh edge clears the missing flag
    a_r7_flag_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_valid_o |-> !sync_missing_o);

endmodule

bind line_ref_phase_det lrpd_checker #(
    .ERR_W (ERR_W)
) u_lrpd_checker (
    .clk_i          (clk_base_i),
    .rst_ni         (rst_ni),
    .sel_ext_i      (sel_ext_i),
    .acq_clk_o      (acq_clk_o),
    .line_ref_o     (line_ref_o),
    .phase_err_o    (phase_err_o),
    .err_valid_o    (err_valid_o),
    .sync_missing_o (sync_missing_o)
);

// File: tb/line_ref_phase_det_tb_top.sv
`timescale 1ns/1ps
module line_ref_phase_det_tb_top;

    localparam int L     = 16;
    localparam int SS    = 2;
    localparam int ERR_W = $clog2(L) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sel_ext = 1'b0;
    logic             ext_acq = 1'b0;
    logic             hsync = 1'b0;
    logic             acq_clk_o;
    logic             line_ref_o;
    logic [ERR_W-1:0] phase_err_o;
    logic             err_valid_o;
    logic             sync_missing_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    bit  ext_run = 0;
    int  ext_div = 0;

    always #5 clk = ~clk;

    // external acquisition clock: period of six base cycles
    always @(posedge clk) begin
        if (ext_run) begin
            if (ext_div == 2) begin
                ext_div <= 0;
                ext_acq <= ~ext_acq;
            end else begin
                ext_div <= ext_div + 1;
            end
        end
    end

    line_ref_phase_det #(
        .LINE_LEN    (L),
        .SYNC_STAGES (SS)
    ) dut_i (
        .clk_base_i     (clk),
        .rst_ni         (rst_n),
        .sel_ext_i      (sel_ext),
        .ext_acq_clk_i  (ext_acq),
        .hsync_i        (hsync),
        .acq_clk_o      (acq_clk_o),
        .line_ref_o     (line_ref_o),
        .phase_err_o    (phase_err_o),
        .err_valid_o    (err_valid_o),
        .sync_missing_o (sync_missing_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_err(input int c);
        int w;
        w = (L - c) % L;
        if (w >= L / 2) w = w - L;
        return w;
    endfunction

    task automatic tick();
        @(posedge acq_clk_o);
        #1;
    endtask

    task automatic do_reset(input bit ext);
        rst_n   = 1'b0;
        sel_ext = ext;
        hsync   = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset values
        check(acq_clk_o == 1'b0, "R9 acq_clk", acq_clk_o, 0);
        check(line_ref_o == 1'b1, "R9 line_ref", line_ref_o, 1);
        check(phase_err_o == '0, "R9 phase_err", int'(phase_err_o), 0);
        check(err_valid_o == 1'b0 && sync_missing_o == 1'b0, "R9 valid/missing",
              int'({err_valid_o, sync_missing_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // raise the sync c acquisition cycles after a reference rising edge
    task automatic measure(input int c, input string tag);
        int n;
        int act;
        @(posedge line_ref_o);
        #1;
        repeat (c) tick();
        hsync = 1'b1;
        n = 0;
        while (!err_valid_o && n < 40) begin
            tick();
            n++;
        end
        act = $signed(phase_err_o);
        check(n == SS + 1, {tag, " R5 latency"}, n, SS + 1);
        check(act == exp_err(c), {tag, " R3 error"}, act, exp_err(c));
        @(posedge clk);
        #1;
        check(err_valid_o == 1'b0, {tag, " R4 strobe width"}, err_valid_o, 0);
        repeat (2) tick();
        hsync = 1'b0;
    endtask

    task automatic widths(input string tag);
        int n;
        @(posedge line_ref_o);
        #1;
        n = 0;
        while (line_ref_o && n < 40) begin tick(); n++; end
        check(n == L / 2, {tag, " R2 high width"}, n, L / 2);
        n = 0;
        while (!line_ref_o && n < 40) begin tick(); n++; end
        check(n == L / 2, {tag, " R2 low width"}, n, L / 2);
    endtask

    initial begin
        int bad;
        int pulses;
        int held;

        // ---------------- internal acquisition clock ----------------
        do_reset(1'b0);

        // R1: toggles on every base edge
        bad = 0;
        @(posedge clk); #1;
        for (int i = 0; i < 12; i++) begin
            logic prev;
            prev = acq_clk_o;
            @(posedge clk); #1;
            if (acq_clk_o == prev) bad++;
        end
        check(bad == 0, "R1 internal toggle", bad, 0);

        widths("int");

        // R3/R5/R4 sweep of every offset in a line
        for (int c = 0; c < L; c++) measure(c, "int");

        // R6: a sync held high for several lines yields one strobe
        @(posedge line_ref_o); #1;
        hsync = 1'b1;
        pulses = 0;
        for (int i = 0; i < 3 * L; i++) begin
            tick();
            if (err_valid_o) pulses++;
        end
        check(pulses == 1, "R6 single strobe for held sync", pulses, 1);
        hsync = 1'b0;
        repeat (4) tick();

        // R7: timeout after a full line with no edge, error held
        measure(3, "r7_pre");
        check(sync_missing_o == 1'b0, "R7 flag clear after edge", sync_missing_o, 0);
        held = $signed(phase_err_o);
        bad = 0;
        for (int i = 0; i < L - 3; i++) begin
            tick();
            if (err_valid_o) bad++;
        end
        check(sync_missing_o == 1'b0, "R7 flag low one cycle early", sync_missing_o, 0);
        check(bad == 0, "R7 no strobe without sync", bad, 0);
        tick();
        check(sync_missing_o == 1'b1, "R7 flag raised at line length", sync_missing_o, 1);
        check($signed(phase_err_o) == held, "R7 error held", $signed(phase_err_o), held);
        repeat (L) tick();
        check(sync_missing_o == 1'b1, "R7 flag stays set", sync_missing_o, 1);
        measure(5, "r7_clear");
        check(sync_missing_o == 1'b0, "R7 flag cleared by edge", sync_missing_o, 0);
        measure(5, "r7_steady");
        check(sync_missing_o == 1'b0, "R7 one-line spacing keeps flag low", sync_missing_o, 0);

        // ---------------- external acquisition clock ----------------
        ext_run = 1'b1;
        do_reset(1'b1);

        // R8: acquisition clock follows the external input one cycle later
        bad = 0;
        for (int i = 0; i < 24; i++) begin
            logic e;
            @(negedge clk);
            e = ext_acq;
            @(posedge clk); #1;
            if (acq_clk_o != e) bad++;
        end
        check(bad == 0, "R8 external clock follow", bad, 0);

        widths("R8 ext");
        for (int c = 0; c < L; c++) measure(c, "R8 ext");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule